// File: doc/BRIEF.md
# Frozen Position Snapshot Byte Reader

This block keeps a snapshot of one or two axis position counters and lets a host with an 8-bit bus read that snapshot one byte at a time. Each axis has a position latch. On every rising clock edge the latch copies its counter, so the snapshot follows the count while nothing is being read.

A shared hold flag stops the copying. Control logic on the falling clock edge samples the active-low output enable. When the enable is seen low, the hold flag is set and both axis latches keep their values. The host can then step through the four bytes and switch axes, and the value does not move under it. When the enable is seen high on a falling edge, the hold flag clears and the latches reload on the next rising edge.

The output pads are modelled as a byte bus plus a drive flag. A per-axis active-low reset clears that axis's latch at once. Any of the resets also clears the shared hold flag.

Top module: `pos_snapshot_reader`

## Requirements
- R1: While the hold flag is clear, each axis latch loads its counter input on every rising clock edge.
- R2: `oe_n` low at a falling clock edge sets the hold flag. From the next rising edge on, both latches keep their values, whatever the counter inputs do.
- R3: `oe_n` high at a falling clock edge clears the hold flag, and the latches load the counters again on the following rising edge.
- R4: The byte presented is chosen by the code {`sel_hi_n`,`sel_lo`}. Code 01 gives bits 31:24, 11 gives bits 23:16, 00 gives bits 15:8 and 10 gives bits 7:0. A full read uses these codes in that order, most significant byte first.
- R5: `d_drive` equals the inverse of `oe_n`. While `oe_n` is high, `d_out` is all zeros.
- R6: With `axis_sel` at 0, the axis 0 latch is presented. With `axis_sel` at 1, the axis 1 latch is presented.
- R7: Driving `rst_n[i]` low clears the axis i latch to zero without waiting for a clock edge. It also clears the shared hold flag. The other axis latch keeps its value.
- R8: A single hold flag serves both axes, so a read freezes both latches on the same edge.
- R9: While the hold flag is set, changing the byte select code or `axis_sel` changes only the byte presented and never the latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Rising edges load the latches; falling edges sample the enable. |
| rst_n | input | 2 | Per-axis active-low asynchronous reset |
| oe_n | input | 1 | Active-low output enable; also starts and ends a read |
| sel_hi_n | input | 1 | First bit of the byte select code |
| sel_lo | input | 1 | Second bit of the byte select code |
| axis_sel | input | 1 | Picks the axis presented (0 or 1) |
| cnt_in | input | 64 | Counter values; axis 0 in bits 31:0, axis 1 in bits 63:32 |
| d_out | output | 8 | Selected byte; zero while not driven |
| d_drive | output | 1 | High while the byte bus is driven |

## Verification
The bench runs a directed four-byte read. During that read the counters change every cycle, and the four bytes must still put back together the value captured before the hold, on both axes. This tells a correct freeze apart from a latch that keeps loading. A second directed read visits the select codes and axes in a scrambled order, which exposes any swapped byte code or axis. Further directed steps cover resetting one axis during a hold and reloading after the enable goes high. A long random run from a fixed seed mixes enable runs of different lengths with changing counters, select codes and axes. It is checked every cycle against a model that samples on both clock edges, so a set or clear of the hold flag one edge early or late shows up as a mismatch.

// File: rtl/qd_snap_pkg.sv
package qd_snap_pkg;

   // Byte select code, written as {sel_hi_n, sel_lo}
   typedef enum logic [1:0] {
      SELC_LOWER  = 2'b00,
      SELC_TOP    = 2'b01,
      SELC_BOTTOM = 2'b10,
      SELC_UPPER  = 2'b11
   } selc_t;

   // Lane index of the byte presented for each select code (3 = most significant)
   function automatic logic [1:0] lane_of(input selc_t code);
      case (code)
         SELC_TOP:    lane_of = 2'd3;
         SELC_UPPER:  lane_of = 2'd2;
         SELC_LOWER:  lane_of = 2'd1;
         default:     lane_of = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/qd_inhibit_ctrl.sv
module qd_inhibit_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_n,
   output logic hold
);

   // Sampled on the falling edge, so the host's enable sets up half a cycle before it
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) hold <= 1'b0;
      else        hold <= ~oe_n;
   end

   // Enable low for a whole cycle means a falling edge saw it low
   assert_hold_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && $past(!oe_n)) |-> hold);

   // Enable high for a whole cycle means a falling edge saw it high
   assert_hold_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n && $past(oe_n)) |-> !hold);

endmodule

// File: rtl/qd_axis_latch.sv
module qd_axis_latch #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (!hold) q <= cnt;
   end

   assert_latch_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> (q == $past(cnt)));

   // Covers R8 and R9 as well: nothing but the hold flag reaches the latch
   assert_latch_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(q));

endmodule

// File: rtl/qd_byte_mux.sv
module qd_byte_mux
   import qd_snap_pkg::*;
#(
   parameter int CNT_W          = 32,
   parameter int BYTE_W         = 8,
   parameter int AXES           = 2,
   parameter bit ZERO_WHEN_IDLE = 1'b1
) (
   input  logic [AXES*CNT_W-1:0] latch_flat,
   input  logic                  axis_sel,
   input  logic                  sel_hi_n,
   input  logic                  sel_lo,
   input  logic                  oe_n,
   output logic [BYTE_W-1:0]     d_out,
   output logic                  d_drive
);

   localparam int NLANE = CNT_W / BYTE_W;

   logic [CNT_W-1:0]  word;
   logic [BYTE_W-1:0] lane [NLANE];
   logic [BYTE_W-1:0] picked;
   selc_t             code;

   generate
      if (AXES == 1) begin : g_one_axis
         assign word = latch_flat[CNT_W-1:0];
      end else begin : g_two_axis
         assign word = axis_sel ? latch_flat[2*CNT_W-1:CNT_W] : latch_flat[CNT_W-1:0];
      end

      for (genvar g = 0; g < NLANE; g++) begin : g_lane
         assign lane[g] = word[g*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign code    = selc_t'({sel_hi_n, sel_lo});
   assign picked  = lane[lane_of(code)];
   assign d_drive = ~oe_n;

   generate
      if (ZERO_WHEN_IDLE) begin : g_zero_idle
         assign d_out = d_drive ? picked : '0;
      end else begin : g_keep_idle
         assign d_out = picked;
      end
   endgenerate

endmodule

// File: rtl/pos_snapshot_reader.sv
module pos_snapshot_reader #(
   parameter int CNT_W          = 32,
   parameter int BYTE_W         = 8,
   parameter int AXES           = 2,
   parameter bit ZERO_WHEN_IDLE = 1'b1
) (
   input  logic                  clk,
   input  logic [AXES-1:0]       rst_n,
   input  logic                  oe_n,
   input  logic                  sel_hi_n,
   input  logic                  sel_lo,
   input  logic                  axis_sel,
   input  logic [AXES*CNT_W-1:0] cnt_in,
   output logic [BYTE_W-1:0]     d_out,
   output logic                  d_drive
);

   localparam int NLANE = CNT_W / BYTE_W;

   generate
      if (NLANE * BYTE_W != CNT_W || NLANE != 4) begin : g_bad_width
         $error("pos_snapshot_reader: CNT_W must be four times BYTE_W");
      end
      if (AXES < 1 || AXES > 2) begin : g_bad_axes
         $error("pos_snapshot_reader: AXES must be 1 or 2");
      end
   endgenerate

   logic                  rst_all_n;
   logic                  hold;
   logic [AXES*CNT_W-1:0] latch_flat;

   // Any axis reset clears the shared hold flag (R7)
   assign rst_all_n = &rst_n;

   qd_inhibit_ctrl u_inh (
      .clk   (clk),
      .rst_n (rst_all_n),
      .oe_n  (oe_n),
      .hold  (hold)
   );

   generate
      for (genvar a = 0; a < AXES; a++) begin : g_axis
         qd_axis_latch #(.CNT_W(CNT_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n[a]),
            .hold  (hold),
            .cnt   (cnt_in[a*CNT_W +: CNT_W]),
            .q     (latch_flat[a*CNT_W +: CNT_W])
         );
      end
   endgenerate

   qd_byte_mux #(
      .CNT_W          (CNT_W),
      .BYTE_W         (BYTE_W),
      .AXES           (AXES),
      .ZERO_WHEN_IDLE (ZERO_WHEN_IDLE)
   ) u_mux (
      .latch_flat (latch_flat),
      .axis_sel   (axis_sel),
      .sel_hi_n   (sel_hi_n),
      .sel_lo     (sel_lo),
      .oe_n       (oe_n),
      .d_out      (d_out),
      .d_drive    (d_drive)
   );

   generate
      if (ZERO_WHEN_IDLE) begin : g_idle_chk
         assert_bus_idle_R5: assert property (@(posedge clk) disable iff (!rst_all_n)
            oe_n |-> (!d_drive && d_out == '0));
      end
   endgenerate

   // R8: one flag for both axes, so a steady latch while frozen holds on every axis
   assert_axes_frozen_R8: assert property (@(posedge clk) disable iff (!rst_all_n)
      hold |=> $stable(latch_flat));

endmodule

// File: tb/tb_pos_snapshot_reader.sv
module tb_pos_snapshot_reader;

   logic        clk = 1'b0;
   logic [1:0]  rst_n;
   logic        oe_n, sel_hi_n, sel_lo, axis_sel;
   logic [63:0] cnt_in;
   logic [7:0]  d_out;
   logic        d_drive;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] m_lat [2];
   logic        m_inh;

   pos_snapshot_reader dut (
      .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .sel_hi_n(sel_hi_n), .sel_lo(sel_lo),
      .axis_sel(axis_sel), .cnt_in(cnt_in), .d_out(d_out), .d_drive(d_drive)
   );

   always #5 clk = ~clk;

   // Reference model taken from the requirements: enable sampled on the falling edge, load on the rising edge
   always @(negedge clk) m_inh = (&rst_n) ? !oe_n : 1'b0;
   always @(posedge clk) begin
      for (int a = 0; a < 2; a++) begin
         if (!rst_n[a])  m_lat[a] = '0;
         else if (!m_inh) m_lat[a] = cnt_in[a*32 +: 32];
      end
   end

   function automatic logic [7:0] sel_byte(input logic [31:0] v, input logic s1, input logic s2);
      case ({s1, s2})
         2'b01:   return v[31:24];
         2'b11:   return v[23:16];
         2'b00:   return v[15:8];
         default: return v[7:0];
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_bus(input string req);
      logic [7:0] eb;
      eb = oe_n ? 8'h00 : sel_byte(m_lat[axis_sel], sel_hi_n, sel_lo);
      chk({req, " drive"}, {31'd0, d_drive}, {31'd0, !oe_n});
      chk({req, " data"}, {24'd0, d_out}, {24'd0, eb});
   endtask

   // Drive one cycle of stimulus after the rising edge, check after the falling edge
   task automatic cyc(input logic oe, input logic s1, input logic s2, input logic ax,
                      input logic [31:0] c0, input logic [31:0] c1, input string req);
      @(posedge clk);
      #1;
      oe_n = oe; sel_hi_n = s1; sel_lo = s2; axis_sel = ax;
      cnt_in = {c1, c0};
      #7;
      chk_bus(req);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] got;
      logic [31:0] old0, old1;
      int unsigned seed;
      int run;
      logic oe_r;
      seed = 32'd1234;
      void'($urandom(seed));
      m_lat[0] = '0; m_lat[1] = '0; m_inh = 1'b0;
      rst_n = 2'b00; oe_n = 1'b0; sel_hi_n = 1'b0; sel_lo = 1'b1; axis_sel = 1'b0;
      cnt_in = {32'h1111_2222, 32'h3333_4444};

      // R7: reset state, reading with the bus driven
      repeat (3) @(posedge clk);
      #8;
      chk("R7 reset axis0 MSB", {24'd0, d_out}, 32'd0);
      axis_sel = 1'b1; #1;
      chk("R7 reset axis1 MSB", {24'd0, d_out}, 32'd0);
      @(posedge clk); #1 rst_n = 2'b11;

      // R5: idle bus while counters move
      for (int i = 0; i < 4; i++) cyc(1'b1, i[0], i[1], i[0], 32'h100 + i, 32'h200 + i, "R5 idle");
      chk("R5 idle zero", {24'd0, d_out}, 32'd0);

      // R1 / R2 / R4 / R8: capture, then a full read while the counters change
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 32'hA1B2_C3D4, 32'h5566_7788, "R1 load");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 32'hDEAD_0001, 32'hBEEF_0001, "R4 msb");
      got[31:24] = d_out;
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 32'hDEAD_0002, 32'hBEEF_0002, "R4 second");
      got[23:16] = d_out;
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 32'hDEAD_0003, 32'hBEEF_0003, "R4 third");
      got[15:8] = d_out;
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 32'hDEAD_0004, 32'hBEEF_0004, "R4 lsb");
      got[7:0] = d_out;
      chk("R2 frozen axis0 word", got, 32'hA1B2_C3D4);
      // R6 / R8 / R9: switch axis and codes in a scrambled order while frozen
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 32'hDEAD_0005, 32'hBEEF_0005, "R6 axis1 lsb");
      got[7:0] = d_out;
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 32'hDEAD_0006, 32'hBEEF_0006, "R6 axis1 msb");
      got[31:24] = d_out;
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 32'hDEAD_0007, 32'hBEEF_0007, "R9 axis1 third");
      got[15:8] = d_out;
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 32'hDEAD_0008, 32'hBEEF_0008, "R9 axis1 second");
      got[23:16] = d_out;
      chk("R8 frozen axis1 word", got, 32'h5566_7788);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 32'hDEAD_0009, 32'hBEEF_0009, "R9 axis0 again");
      chk("R9 axis0 msb unchanged", {24'd0, d_out}, 32'h0000_00A1);

      // R3: enable high releases; reload on the next rising edge
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 32'hCAFE_F00D, 32'h0BAD_F00D, "R3 release");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 32'h1357_9BDF, 32'h2468_ACE0, "R3 reload msb");
      chk("R3 reloaded msb", {24'd0, d_out}, 32'h0000_00CA);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 32'h1357_9BDF, 32'h2468_ACE0, "R3 reload axis1 lsb");
      chk("R3 reloaded axis1 lsb", {24'd0, d_out}, 32'h0000_000D);

      // R7: reset axis1 alone while frozen
      @(posedge clk); #3;
      rst_n = 2'b01; m_lat[1] = '0; m_inh = 1'b0;
      #5;
      axis_sel = 1'b1; sel_hi_n = 1'b1; sel_lo = 1'b0; #1;
      chk("R7 axis1 cleared", {24'd0, d_out}, 32'd0);
      axis_sel = 1'b0; #1;
      chk("R7 axis0 kept", {24'd0, d_out}, 32'h0000_000D);
      @(posedge clk); #1 rst_n = 2'b11;

      // Random enable runs, selects, axes and counters
      run = 0; oe_r = 1'b1;
      for (int i = 0; i < 600; i++) begin
         string tag;
         if (run == 0) begin
            oe_r = ~oe_r;
            run  = 1 + ($urandom % 6);
         end
         run--;
         if (oe_r)          tag = "R5 random idle";
         else if (m_inh)    tag = "R9 random frozen";
         else               tag = "R1 random load";
         cyc(oe_r, 1'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom, tag);
      end

      // Long hold: counters run on but both words stay put (R8)
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 32'h0F0F_0F0F, 32'hF0F0_F0F0, "R1 pre hold");
      old0 = 32'h0F0F_0F0F; old1 = 32'hF0F0_F0F0;
      for (int i = 0; i < 20; i++)
         cyc(1'b0, 1'b1, 1'b0, 1'(i), $urandom, $urandom, "R8 long hold");
      chk("R8 axis1 lsb after hold", {24'd0, d_out}, {24'd0, old1[7:0]});
      axis_sel = 1'b0; #1;
      chk("R8 axis0 lsb after hold", {24'd0, d_out}, {24'd0, old0[7:0]});

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule